// File: doc/BRIEF.md
# Pulse-Width Modulator with Queued Duty Updates and Edge-Safe Mode

This block drives one pulse-width output from a free-running period counter. The counter runs from zero up to one less than the programmed period length and then wraps. The output goes active at each wrap when the compare value for the new period is nonzero. It falls when the counter reaches that compare value, so the number of active cycles in a period equals the compare value.

New compare values come in through a single-cycle write strobe. They pass through a small queue that releases one entry at each wrap. A write that arrives while the queue is empty bypasses the queue and replaces the compare value right away.

In legacy mode that bypass is unconditional. A late write of a smaller value can therefore land after the counter has already passed it, and the period then ends with no falling edge. In safe mode the block recognises this window and sends such a write into the queue instead, so it takes effect at the next wrap. All other writes keep the immediate path, so a long period never delays an update that could not cause harm. A fill-level output and a sticky overflow flag report the state of the queue.

Top module: `pwm_qduty_top`

## Requirements
- R1: While reset is held, the output is low, the fill level is 0, the overflow flag is 0 and the counter value is 0; the compare value after reset is 0.
- R2: The counter counts up by one each cycle and wraps to 0 after reaching period_len-1. For a compare value C with 0 < C < period_len, the output is high for counter values 0 to C-1 and low for the rest, with exactly one falling edge per period.
- R3: A compare value of 0 keeps the output low for the whole period. A compare value of period_len or more keeps it high for the whole period with no falling edge.
- R4: A write while the queue is empty changes the compare value for the running period, effective from the next cycle. This applies in legacy mode always, and in safe mode when the write is outside the hazard window. A write in the wrap cycle becomes the compare value of the period that starts.
- R5: In legacy mode (mode_safe=0), a write of a value V below the current compare value C, made at counter value N with V <= N < C, leaves the output high for the whole period (no falling edge).
- R6: In safe mode (mode_safe=1), a write in the same window (V < C, V <= N < C, queue empty, not the wrap cycle) is queued instead. The running period keeps duty C and the next period has duty V.
- R7: Queued values become the compare value one per wrap, in write order. When the queue is empty, the last compare value is kept.
- R8: fill_level reports the number of occupied queue entries, from 0 to DEPTH (default 4), and is updated in the cycle after a push or pop.
- R9: A write while the queue is full and not popping is dropped: the stored entries are unchanged, and ovf_flag goes to 1 and stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_safe | input | 1 | 0 = legacy immediate update, 1 = edge-safe update |
| period_len | input | CNT_W | Period length in cycles (at least 2) |
| wr_en | input | 1 | Duty write strobe, one value per cycle |
| wr_data | input | CNT_W | Duty value written |
| pwm_out | output | 1 | Modulated output |
| fill_level | output | LVL_W | Number of occupied queue entries |
| ovf_flag | output | 1 | Sticky overflow flag |
| count_o | output | CNT_W | Current period counter value |

## Verification
The assertions take period_len to be at least 2 and to stay constant while the block runs. The counter-step and rise-at-wrap properties only hold under that condition. The bench therefore fixes period_len at 20 for the whole run and changes only the mode and the written values. It starts each write at a period boundary, so the hazard window and the full-queue case are entered deliberately. It judges each period by its count of active cycles and falling edges.

// File: rtl/pwm_qduty_pkg.sv
// Package: types shared by the queued-duty pulse-width modulator.
// Assumes nothing beyond being compiled before the modules that import it.
package pwm_qduty_pkg;

    typedef enum logic {
        UPD_LEGACY = 1'b0,
        UPD_SAFE   = 1'b1
    } upd_mode_e;

endpackage

// File: rtl/pwm_period_ctr.sv
// Period counter: counts from 0 to period_len-1, then wraps to 0.
// Gives the current value, the next value and a wrap strobe for the current cycle.
// Assumes period_len >= 2 and that it is held steady while running.
module pwm_period_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_len,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             wrap
);

    // Detect the last count of the period and form the next count.
    always_comb begin
        wrap    = (cnt_q >= (period_len - 1'b1));
        cnt_nxt = wrap ? '0 : cnt_q + 1'b1;
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
    end

    // R2: a nonzero count is always its predecessor plus one.
    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/pwm_sample_q.sv
// Sample queue: DEPTH entries, first in first out, with a fill-level count and a sticky overflow flag.
// A push into a full queue that is not popping in the same cycle is dropped.
// Assumes pop is raised only when the queue is not empty.
module pwm_sample_q #(
    parameter int W     = 16,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic             empty,
    output logic             full,
    output logic [LVL_W-1:0] level,
    output logic             ovf_q
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             push_ok;
    logic             pop_ok;

    // Status decode and accepted push/pop.
    always_comb begin
        empty   = (level == '0);
        full    = (level == LVL_W'(DEPTH));
        pop_ok  = pop && !empty;
        push_ok = push && (!full || pop_ok);
        head    = mem[rd_ptr];
    end

    // One storage register per entry, written when the write pointer selects it.
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (push_ok && (wr_ptr == PTR_W'(i))) mem[i] <= push_data;
        end
    end

    // Pointer, level and overflow bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (push_ok)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
            if (push && !push_ok) ovf_q <= 1'b1;
        end
    end

    // R8: the level never exceeds the depth.
    assert_level_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    // R9: once set, the overflow flag stays set.
    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);

    // R9: a dropped push leaves the queue full and the stored entries in place.
    assert_full_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (full && $stable(rd_ptr) && $stable(wr_ptr)));

endmodule

// File: rtl/pwm_cmp_ctl.sv
// Compare control: chooses, in each cycle, whether a write updates the compare value at once or goes into the queue.
// Pops the queue at wrap and drives the output register.
// In safe mode, a write that would leave the period without a falling edge is queued.
// Assumes the counter signals come from pwm_period_ctr.
module pwm_cmp_ctl
    import pwm_qduty_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_safe,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic             wrap,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             q_empty,
    input  logic [CNT_W-1:0] q_head,
    output logic             q_push,
    output logic             q_pop,
    output logic [CNT_W-1:0] cmp_q,
    output logic             pwm_q
);

    upd_mode_e        mode;
    logic             in_window;
    logic             bypass;
    logic [CNT_W-1:0] cmp_nxt;
    logic             pwm_nxt;

    // Decide the update path for this cycle's write.
    always_comb begin
        mode      = upd_mode_e'(mode_safe);
        in_window = (wr_data < cmp_q) && (wr_data <= cnt_q) && (cnt_q < cmp_q);
        bypass    = wr_en && q_empty &&
                    (wrap || !((mode == UPD_SAFE) && in_window));
        q_push    = wr_en && !bypass;
        q_pop     = wrap && !q_empty;
    end

    // Next compare value and next output level.
    always_comb begin
        if (q_pop)       cmp_nxt = q_head;
        else if (bypass) cmp_nxt = wr_data;
        else             cmp_nxt = cmp_q;
        if (wrap)                     pwm_nxt = (cmp_nxt != '0);
        else if (cnt_nxt == cmp_nxt)  pwm_nxt = 1'b0;
        else                          pwm_nxt = pwm_q;
    end

    // Compare and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
            pwm_q <= 1'b0;
        end else begin
            cmp_q <= cmp_nxt;
            pwm_q <= pwm_nxt;
        end
    end

    // R2: the output rises only at the start of a period.
    assert_rise_at_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_q) |-> (cnt_q == '0));

    // R3: a zero compare value at period start means a low output.
    assert_zero_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_q == '0) && (cmp_q == '0)) |-> !pwm_q);

    // R6: in safe mode, a write inside the hazard window leaves the running compare value untouched.
    assert_safe_defer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_safe && wr_en && !wrap && (wr_data < cmp_q) && (wr_data <= cnt_q) && (cnt_q < cmp_q))
        |=> (cmp_q == $past(cmp_q)));

endmodule

// File: rtl/pwm_qduty_top.sv
// Top: pulse-width modulator with a duty queue and a selectable edge-safe update mode.
// Joins the period counter, the sample queue and the compare control.
// Assumes period_len >= 2, held steady while running.
module pwm_qduty_top #(
    parameter int CNT_W = 16,
    parameter int DEPTH = 4,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_safe,
    input  logic [CNT_W-1:0] period_len,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pwm_out,
    output logic [LVL_W-1:0] fill_level,
    output logic             ovf_flag,
    output logic [CNT_W-1:0] count_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             wrap;
    logic             q_push;
    logic             q_pop;
    logic [CNT_W-1:0] q_head;
    logic             q_empty;
    logic             q_full;
    logic [CNT_W-1:0] cmp_q;

    pwm_period_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_len (period_len),
        .cnt_q      (cnt_q),
        .cnt_nxt    (cnt_nxt),
        .wrap       (wrap)
    );

    pwm_sample_q #(.W(CNT_W), .DEPTH(DEPTH)) u_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_data (wr_data),
        .pop       (q_pop),
        .head      (q_head),
        .empty     (q_empty),
        .full      (q_full),
        .level     (fill_level),
        .ovf_q     (ovf_flag)
    );

    pwm_cmp_ctl #(.CNT_W(CNT_W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_safe (mode_safe),
        .cnt_q     (cnt_q),
        .cnt_nxt   (cnt_nxt),
        .wrap      (wrap),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .q_empty   (q_empty),
        .q_head    (q_head),
        .q_push    (q_push),
        .q_pop     (q_pop),
        .cmp_q     (cmp_q),
        .pwm_q     (pwm_out)
    );

    // Expose the counter value.
    always_comb count_o = cnt_q;

    // R8: a full queue is never reported as empty.
    assert_full_not_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> !q_empty);

endmodule

// File: tb/sim_pwm_qduty_top.sv
module sim_pwm_qduty_top;

    localparam int CNT_W = 16;
    localparam int DEPTH = 4;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int PER   = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_safe = 1'b0;
    logic [CNT_W-1:0] period_len = CNT_W'(PER);
    logic             wr_en = 1'b0;
    logic [CNT_W-1:0] wr_data = '0;
    logic             pwm_out;
    logic [LVL_W-1:0] fill_level;
    logic             ovf_flag;
    logic [CNT_W-1:0] count_o;

    int total = 0;
    int bad   = 0;

    typedef struct {
        int    hi;
        int    falls;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    pwm_qduty_top #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_safe  (mode_safe),
        .period_len (period_len),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .pwm_out    (pwm_out),
        .fill_level (fill_level),
        .ovf_flag   (ovf_flag),
        .count_o    (count_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic expect_period(input int hi, input int falls, input string tag);
        exp_t e;
        e.hi = hi;
        e.falls = falls;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic wait_count(input int c);
        while (count_o != CNT_W'(c)) @(negedge clk);
    endtask

    task automatic write_at(input int c, input int d);
        wait_count(c);
        wr_en = 1'b1;
        wr_data = CNT_W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // Monitor: measures each period and compares it with the next expected record.
    int  mon_hi = 0;
    int  mon_falls = 0;
    bit  mon_seen = 0;
    bit  mon_prev = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (count_o == '0) begin
                if (mon_seen && exp_q.size() > 0) begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(mon_hi == e.hi, {e.tag, " active cycles"}, mon_hi, e.hi);
                    check(mon_falls == e.falls, {e.tag, " falling edges"}, mon_falls, e.falls);
                end
                mon_seen = 1;
                mon_hi = pwm_out ? 1 : 0;
                mon_falls = 0;
            end else begin
                if (pwm_out) mon_hi++;
                if (mon_prev && !pwm_out) mon_falls++;
            end
            mon_prev = pwm_out;
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(pwm_out == 1'b0, "R1 output", int'(pwm_out), 0);
        check(fill_level == '0, "R1 fill", int'(fill_level), 0);
        check(ovf_flag == 1'b0, "R1 ovf", int'(ovf_flag), 0);
        check(count_o == '0, "R1 count", int'(count_o), 0);
        rst_n = 1'b1;
        repeat (PER + 2) @(negedge clk);

        // R4 / R2: legacy immediate raise from 0 to 10
        settle();
        write_at(2, 10);
        check(fill_level == '0, "R4 fill after immediate", int'(fill_level), 0);
        expect_period(0, 0, "R4 running period");
        expect_period(10, 1, "R2 duty 10");
        expect_period(10, 1, "R2 duty 10 again");

        // R5: legacy late decrease 10 -> 4 at count 7 skips the falling edge
        settle();
        write_at(7, 4);
        expect_period(PER, 0, "R5 skipped edge");
        expect_period(4, 1, "R5 next period");

        // R4: legacy increase 4 -> 10 after the fall
        settle();
        write_at(15, 10);
        expect_period(4, 1, "R4 late increase");
        expect_period(10, 1, "R4 increase applied");

        // R6: safe mode defers the same late decrease
        settle();
        mode_safe = 1'b1;
        write_at(7, 4);
        check(fill_level == LVL_W'(1), "R6 queued", int'(fill_level), 1);
        expect_period(10, 1, "R6 keeps old duty");
        expect_period(4, 1, "R6 new duty next period");

        // R4: safe mode decrease outside the window applies at once
        settle();
        check(fill_level == '0, "R7 queue drained", int'(fill_level), 0);
        write_at(2, 3);
        check(fill_level == '0, "R4 safe immediate not queued", int'(fill_level), 0);
        expect_period(3, 1, "R4 safe immediate");

        // R4: safe increase 3 -> 8 applies at once
        settle();
        write_at(10, 8);
        expect_period(3, 1, "R4 safe increase running");
        expect_period(8, 1, "R4 safe increase applied");

        // R7 / R8 / R9: fill the queue, overflow, drain in order
        settle();
        write_at(6, 2);
        write_at(7, 5);
        write_at(8, 7);
        write_at(9, 9);
        check(fill_level == LVL_W'(4), "R8 full level", int'(fill_level), 4);
        check(ovf_flag == 1'b0, "R9 no overflow yet", int'(ovf_flag), 0);
        write_at(10, 11);
        check(fill_level == LVL_W'(4), "R9 level after drop", int'(fill_level), 4);
        check(ovf_flag == 1'b1, "R9 overflow set", int'(ovf_flag), 1);
        expect_period(8, 1, "R7 running 8");
        expect_period(2, 1, "R7 entry 2");
        expect_period(5, 1, "R7 entry 5");
        expect_period(7, 1, "R7 entry 7");
        expect_period(9, 1, "R7 entry 9");
        expect_period(9, 1, "R9 dropped value absent");
        settle();
        check(fill_level == '0, "R8 drained level", int'(fill_level), 0);
        check(ovf_flag == 1'b1, "R9 overflow sticky", int'(ovf_flag), 1);

        // R3: compare at or above period, then zero
        mode_safe = 1'b0;
        write_at(12, 25);
        expect_period(9, 1, "R3 running 9");
        expect_period(PER, 0, "R3 full high");
        expect_period(PER, 0, "R3 full high again");
        settle();
        write_at(3, 0);
        expect_period(PER, 0, "R3 zero written late");
        expect_period(0, 0, "R3 zero low");
        expect_period(0, 0, "R3 zero low again");
        settle();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule